// File: doc/BRIEF.md
# Multidrop Address-Gated Receive Filter

This block sits between the character deserializer of a serial receiver and its receive FIFO, on a multidrop link where every character carries a ninth bit. When that bit is 1, the character is a station address; when it is 0, the character is data. The filter decides, one character at a time, whether the character reaches the FIFO. It also keeps a persistent gate state: while the gate is locked, data characters are kept out of the FIFO.

A 2-bit policy input chooses how address characters act on the gate. The first policy only reports addresses. The second opens the gate on any address. The third opens the gate when the address equals the programmed station address and locks it when the address differs. Software can also lock or unlock the gate with single-cycle strobes. A sticky flag records that an address character arrived, and a read-acknowledge strobe clears it.

All outputs are registered. A character presented in cycle t produces its FIFO write, or its drop pulse, in cycle t+1, and the new gate state appears at the same edge.

Top module: `afg_rx_filter`

## Requirements
- R1: After reset, `gate_locked`, `addr_seen_flag`, `fifo_we` and `char_dropped` are all 0.
- R2: With `policy` = 2'b00 (report only), every address character is written to the FIFO and sets `addr_seen_flag`. The gate state is not changed by the address.
- R3: With `policy` = 2'b01 (open on any address), every address character is written to the FIFO and the gate is unlocked at the next edge.
- R4: With `policy` = 2'b01, the filter never locks the gate on its own, even when the address differs from `station_addr`.
- R5: With `policy` = 2'b10 (match-driven), an address equal to `station_addr` is written to the FIFO and unlocks the gate.
- R6: With `policy` = 2'b10, an address that differs from `station_addr` locks the gate. That address is not written to the FIFO and raises `char_dropped` for one cycle.
- R7: `policy` = 2'b11 behaves exactly like 2'b00.
- R8: A data character (`rx_addr_bit` = 0) that arrives while the gate is locked gives no `fifo_we`. It gives a one-cycle `char_dropped` instead. `fifo_we` and `char_dropped` are never high together.
- R9: A data character that arrives while the gate is unlocked gives `fifo_we` = 1 with `fifo_wdata` equal to the character, one cycle after `rx_valid`.
- R10: `sw_lock` locks the gate and `sw_unlock` unlocks it at the next edge. When both are asserted together, the lock wins.
- R11: When an address character causes an open or lock decision (policies 01 and 10) in the same cycle as a software strobe, the address decision sets the gate state.
- R12: `addr_ack` clears `addr_seen_flag` at the next edge. An address character that arrives in the same cycle as `addr_ack` leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | A received character is present this cycle |
| rx_char | input | CHAR_W | Received character |
| rx_addr_bit | input | 1 | Ninth bit: 1 = address, 0 = data |
| policy | input | 2 | Address policy: 00 report, 01 open on any, 10 match-driven, 11 as 00 |
| station_addr | input | CHAR_W | Address of this station |
| sw_lock | input | 1 | Software strobe: lock the gate |
| sw_unlock | input | 1 | Software strobe: unlock the gate |
| addr_ack | input | 1 | Read-acknowledge: clears the address flag |
| fifo_we | output | 1 | Write enable toward the receive FIFO |
| fifo_wdata | output | CHAR_W | Character written to the FIFO |
| gate_locked | output | 1 | Gate state: 1 = locked |
| addr_seen_flag | output | 1 | Sticky flag: an address character was received |
| char_dropped | output | 1 | One-cycle pulse: a character was kept out of the FIFO |

## Verification
The bench builds the block with the default CHAR_W of 8. This puts station addresses such as 0x5A, and mismatching neighbours that differ from it in a single bit, within reach, so a partial compare would be exposed. The bench runs every policy value, including the reserved one, and alternates address and data characters so that the gate state left by one address controls the data behind it. It also drives software strobes and acknowledges in the same cycle as address decisions to exercise the priority rules.

// File: rtl/afg_pkg.sv
package afg_pkg;
    typedef enum logic [1:0] {
        POL_REPORT = 2'b00,
        POL_OPEN   = 2'b01,
        POL_MATCH  = 2'b10,
        POL_RSVD   = 2'b11
    } afg_policy_e;

    typedef enum logic [1:0] {
        DEC_NONE  = 2'b00,
        DEC_OPEN  = 2'b01,
        DEC_CLOSE = 2'b10
    } afg_decision_e;
endpackage

// File: rtl/afg_addr_match.sv
module afg_addr_match #(
    parameter int W = 8
) (
    input  logic [W-1:0] rx_char,
    input  logic [W-1:0] station_addr,
    output logic         match
);
    logic [W-1:0] bit_eq;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bit_eq[i] = ~(rx_char[i] ^ station_addr[i]);
    end

    assign match = &bit_eq;
endmodule

// File: rtl/afg_policy.sv
module afg_policy
    import afg_pkg::*;
(
    input  afg_policy_e   policy,
    input  logic          addr_seen,
    input  logic          match,
    output afg_decision_e decision,
    output logic          addr_keep
);
    always_comb begin
        decision  = DEC_NONE;
        addr_keep = 1'b1;
        unique case (policy)
            POL_OPEN: begin
                if (addr_seen) decision = DEC_OPEN;
            end
            POL_MATCH: begin
                addr_keep = match;
                if (addr_seen) decision = match ? DEC_OPEN : DEC_CLOSE;
            end
            default: begin
                decision = DEC_NONE;
            end
        endcase
    end
endmodule

// File: rtl/afg_rx_filter.sv
module afg_rx_filter
    import afg_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic              rx_addr_bit,
    input  logic [1:0]        policy,
    input  logic [CHAR_W-1:0] station_addr,
    input  logic              sw_lock,
    input  logic              sw_unlock,
    input  logic              addr_ack,
    output logic              fifo_we,
    output logic [CHAR_W-1:0] fifo_wdata,
    output logic              gate_locked,
    output logic              addr_seen_flag,
    output logic              char_dropped
);
    typedef struct packed {
        logic              locked;
        logic              flag;
        logic              we;
        logic              drop;
        logic [CHAR_W-1:0] data;
    } filt_state_t;

    filt_state_t   s_d, s_q;
    logic          addr_match;
    logic          addr_keep;
    logic          keep;
    afg_decision_e decision;

    afg_addr_match #(.W(CHAR_W)) u_match (
        .rx_char      (rx_char),
        .station_addr (station_addr),
        .match        (addr_match)
    );

    afg_policy u_policy (
        .policy    (afg_policy_e'(policy)),
        .addr_seen (rx_valid & rx_addr_bit),
        .match     (addr_match),
        .decision  (decision),
        .addr_keep (addr_keep)
    );

    always_comb begin
        s_d      = s_q;
        s_d.we   = 1'b0;
        s_d.drop = 1'b0;
        keep     = 1'b0;

        if (rx_valid) begin
            keep     = rx_addr_bit ? addr_keep : ~s_q.locked;
            s_d.data = rx_char;
            s_d.we   = keep;
            s_d.drop = ~keep;
        end

        unique case (decision)
            DEC_OPEN:  s_d.locked = 1'b0;
            DEC_CLOSE: s_d.locked = 1'b1;
            default: begin
                if (sw_lock)        s_d.locked = 1'b1;
                else if (sw_unlock) s_d.locked = 1'b0;
            end
        endcase

        if (rx_valid && rx_addr_bit) s_d.flag = 1'b1;
        else if (addr_ack)           s_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fifo_we        = s_q.we;
    assign fifo_wdata     = s_q.data;
    assign gate_locked    = s_q.locked;
    assign addr_seen_flag = s_q.flag;
    assign char_dropped   = s_q.drop;
endmodule

// File: rtl/afg_rx_filter_chk.sv
module afg_rx_filter_chk #(
    parameter int CHAR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic [CHAR_W-1:0] rx_char,
    input logic              rx_addr_bit,
    input logic [1:0]        policy,
    input logic [CHAR_W-1:0] station_addr,
    input logic              sw_lock,
    input logic              sw_unlock,
    input logic              addr_ack,
    input logic              fifo_we,
    input logic              gate_locked,
    input logic              addr_seen_flag,
    input logic              char_dropped
);
    p_we_drop_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_we && char_dropped));

    p_report_holds_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_addr_bit && policy == 2'b00 && !sw_lock && !sw_unlock)
        |=> $stable(gate_locked) && fifo_we);

    p_open_unlocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_addr_bit && policy == 2'b01) |=> !gate_locked && fifo_we);

    p_mismatch_locks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_addr_bit && policy == 2'b10 && rx_char != station_addr)
        |=> gate_locked && char_dropped);

    p_locked_data_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_addr_bit && gate_locked) |=> !fifo_we && char_dropped);

    p_sw_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_lock && !(rx_valid && rx_addr_bit && (policy == 2'b01 || policy == 2'b10)))
        |=> gate_locked);

    p_flag_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_addr_bit) |=> addr_seen_flag);
endmodule

bind afg_rx_filter afg_rx_filter_chk #(.CHAR_W(CHAR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rx_valid       (rx_valid),
    .rx_char        (rx_char),
    .rx_addr_bit    (rx_addr_bit),
    .policy         (policy),
    .station_addr   (station_addr),
    .sw_lock        (sw_lock),
    .sw_unlock      (sw_unlock),
    .addr_ack       (addr_ack),
    .fifo_we        (fifo_we),
    .gate_locked    (gate_locked),
    .addr_seen_flag (addr_seen_flag),
    .char_dropped   (char_dropped)
);

// File: tb/sim_afg_rx_filter.sv
module sim_afg_rx_filter;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_valid = 1'b0;
    logic [CW-1:0] rx_char = '0;
    logic          rx_addr_bit = 1'b0;
    logic [1:0]    policy = 2'b00;
    logic [CW-1:0] station_addr = 8'h5A;
    logic          sw_lock = 1'b0;
    logic          sw_unlock = 1'b0;
    logic          addr_ack = 1'b0;
    logic          fifo_we;
    logic [CW-1:0] fifo_wdata;
    logic          gate_locked;
    logic          addr_seen_flag;
    logic          char_dropped;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    bit            m_locked = 0, m_flag = 0, m_we = 0, m_drop = 0;
    logic [CW-1:0] m_data = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    afg_rx_filter #(.CHAR_W(CW)) u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .rx_valid       (rx_valid),
        .rx_char        (rx_char),
        .rx_addr_bit    (rx_addr_bit),
        .policy         (policy),
        .station_addr   (station_addr),
        .sw_lock        (sw_lock),
        .sw_unlock      (sw_unlock),
        .addr_ack       (addr_ack),
        .fifo_we        (fifo_we),
        .fifo_wdata     (fifo_wdata),
        .gate_locked    (gate_locked),
        .addr_seen_flag (addr_seen_flag),
        .char_dropped   (char_dropped)
    );

    task automatic check(string tag, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        check(tag, "fifo_we", int'(fifo_we), int'(m_we));
        check(tag, "char_dropped", int'(char_dropped), int'(m_drop));
        check(tag, "gate_locked", int'(gate_locked), int'(m_locked));
        check(tag, "addr_seen_flag", int'(addr_seen_flag), int'(m_flag));
        if (m_we) check(tag, "fifo_wdata", int'(fifo_wdata), int'(m_data));
    endtask

    task automatic step(string tag, bit v, bit a, logic [CW-1:0] ch, logic [1:0] pol,
                        bit sl, bit su, bit ack);
        bit keep;
        bit auto_dec;
        rx_valid = v; rx_addr_bit = a; rx_char = ch; policy = pol;
        sw_lock = sl; sw_unlock = su; addr_ack = ack;
        @(posedge clk);
        keep = 0;
        if (v) begin
            if (a) keep = (pol == 2'b10) ? (ch == station_addr) : 1'b1;
            else   keep = !m_locked;
            m_data = ch;
        end
        m_we   = v && keep;
        m_drop = v && !keep;
        auto_dec = v && a && (pol == 2'b01 || pol == 2'b10);
        if (auto_dec)       m_locked = (pol == 2'b10) ? (ch != station_addr) : 1'b0;
        else if (sl)        m_locked = 1'b1;
        else if (su)        m_locked = 1'b0;
        if (v && a)         m_flag = 1'b1;
        else if (ack)       m_flag = 1'b0;
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        compare_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R1");

        // R9 data while unlocked
        step("R9", 1, 0, 8'h11, 2'b00, 0, 0, 0);
        step("R9", 1, 0, 8'hEE, 2'b00, 0, 0, 0);
        // R10 software lock, then data dropped (R8)
        step("R10", 0, 0, 8'h00, 2'b00, 1, 0, 0);
        step("R8", 1, 0, 8'h22, 2'b00, 0, 0, 0);
        // R2 report mode address: written, lock held
        step("R2", 1, 1, 8'h33, 2'b00, 0, 0, 0);
        step("R8", 1, 0, 8'h44, 2'b00, 0, 0, 0);
        // R12 ack clears flag
        step("R12", 0, 0, 8'h00, 2'b00, 0, 0, 1);
        // R7 reserved behaves as report
        step("R7", 1, 1, 8'h5A, 2'b11, 0, 0, 0);
        step("R7", 1, 0, 8'h55, 2'b11, 0, 0, 0);
        // R12 address and ack together: flag stays set
        step("R12", 1, 1, 8'h01, 2'b00, 0, 0, 1);
        // R3 open on any address
        step("R3", 1, 1, 8'h77, 2'b01, 0, 0, 0);
        step("R9", 1, 0, 8'h78, 2'b01, 0, 0, 0);
        // R4 mismatch in open policy leaves gate open
        step("R4", 1, 1, 8'h5B, 2'b01, 0, 0, 0);
        step("R4", 1, 0, 8'h79, 2'b01, 0, 0, 0);
        // R6 mismatch in match policy, one-bit difference
        step("R6", 1, 1, 8'hDA, 2'b10, 0, 0, 0);
        step("R8", 1, 0, 8'h80, 2'b10, 0, 0, 0);
        // R5 match opens
        step("R5", 1, 1, 8'h5A, 2'b10, 0, 0, 0);
        step("R9", 1, 0, 8'h81, 2'b10, 0, 0, 0);
        // R11 mismatch beats unlock strobe
        step("R11", 1, 1, 8'h5E, 2'b10, 0, 1, 0);
        // R11 match beats lock strobe
        step("R11", 1, 1, 8'h5A, 2'b10, 1, 0, 0);
        // R11 open-any beats lock strobe
        step("R11", 1, 1, 8'h12, 2'b01, 1, 0, 0);
        // R10 both strobes: lock wins; then unlock
        step("R10", 0, 0, 8'h00, 2'b10, 1, 1, 0);
        step("R10", 0, 0, 8'h00, 2'b10, 0, 1, 0);
        // R2 report-mode address with strobe: strobe still applies
        step("R2", 1, 1, 8'h5A, 2'b00, 1, 0, 0);
        step("R8", 1, 0, 8'h90, 2'b00, 0, 0, 0);
        step("R1", 0, 0, 8'h00, 2'b00, 0, 0, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule